// File: doc/BRIEF.md
# Scrambler with Automatic Sync Acquisition

This block is a 23-stage self-synchronizing serial scrambler for the symbol detector of a line transceiver. One shift register serves two roles. As a descrambler it shifts each detected bit in and XORs that bit with two delayed taps. As a scrambled-ones generator it ignores the detected bit, scrambles a constant 1 and shifts its own output back in. A select input chooses between two tap sets.

An automatic lock sequence can override the mode input. First it runs the register as a descrambler for a training phase, which loads it with the far-end state. It then switches to scrambled-ones generation for a fixed compare window. During the window it counts the symbols in which the generated bit agrees with the detected bit. If that count goes strictly above a programmable threshold, a sticky sync flag is raised and the block stays in generator mode. If the window ends first, training starts again. All advance is gated by a per-symbol enable.

Top module: `scr_autosync`

## Requirements
- R1: With `poly_sel`=1 the feedback taps are the register stages holding the bits of 18 and 23 symbols ago.
- R2: With `poly_sel`=0 the feedback taps are the stages holding the bits of 5 and 23 symbols ago.
- R3: In descrambler mode (`desc_mode`=1, lock off), each enabled symbol gives `scr_out` = `det_bit` XOR both taps, and `det_bit` is shifted into the register. There is no feedback, so a single 1 after reset reappears only at the two tap delays.
- R4: In generator mode (`desc_mode`=0, lock off), `scr_out` = 1 XOR both taps, the output is shifted back in, and `det_bit` has no effect on `scr_out`.
- R5: Synchronous reset clears the register, `scr_out` and `sync_irq`. On cycles with `sym_en`=0, `scr_out` and the register keep their values.
- R6: While `lock_en`=1, `desc_mode` is ignored. The cycle in which lock is first seen runs as a descrambler. It is followed by 23 enabled descrambler symbols and then by a window of 128 enabled generator symbols.
- R7: In the window, each symbol with generated bit equal to `det_bit` adds one to a match count. `sync_irq` rises at the edge of the first symbol at which the count exceeds `sync_thr` (unsigned, strictly greater). The block then stays in generator mode.
- R8: If the window ends without exceeding the threshold, the count is cleared and training restarts. A threshold of 127 is reached only by the last symbol of a fully matching window, and a threshold of 128 is never reached.
- R9: `irq_clr` has no effect on `sync_irq` while `lock_en`=1. With `lock_en`=0 it clears the flag at the next edge.
- R10: Dropping `lock_en` aborts the sequence at once and returns to the mode chosen by `desc_mode`. Raising it again restarts from training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | Symbol enable; block advances only when high |
| det_bit | input | 1 | Detected bit from slicer/peak detector |
| poly_sel | input | 1 | Tap set select (1: 18/23, 0: 5/23) |
| desc_mode | input | 1 | 1: descrambler, 0: scrambled-ones generator |
| lock_en | input | 1 | Enables the automatic lock sequence |
| sync_thr | input | 8 | Match count threshold (strictly exceeded) |
| irq_clr | input | 1 | Clear strobe for the sync flag |
| scr_out | output | 1 | Registered scrambler/descrambler output |
| sync_irq | output | 1 | Sticky sync flag |

## Verification
The bench builds the block with its default sizes: a 23-stage register, a 23-symbol training phase, a 128-symbol window and an 8-bit threshold. With these sizes the match counter can reach exactly 128. Thresholds of 127 and 128 then sit on the boundary between the last possible sync and no sync at all. A far-end scrambled-ones stream from a second behavioural register lets the bench predict the exact symbol at which the flag rises, including after a window that fails and training that restarts.

// File: rtl/scr_sync_pkg.sv
package scr_sync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_TRAIN  = 2'd1,
    PH_WINDOW = 2'd2,
    PH_LOCKED = 2'd3
  } lock_phase_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core
  import scr_sync_pkg::*;
#(
  parameter int SR_LEN   = 23,
  parameter int TAP_SEL1 = 18,
  parameter int TAP_SEL0 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic desc_eff,
  input  logic poly_sel,
  input  logic rx_bit,
  output logic out_nx,
  output logic out_q
);

  logic [SR_LEN-1:0] sr;
  logic              tap_mid;
  logic              data_in;
  logic              shift_bit;

  // tap choice: one tap set per select value
  generate
    if (TAP_SEL1 == TAP_SEL0) begin : g_single_tap
      assign tap_mid = sr[TAP_SEL1-1];
    end else begin : g_dual_tap
      assign tap_mid = poly_sel ? sr[TAP_SEL1-1] : sr[TAP_SEL0-1];
    end
  endgenerate

  assign data_in   = desc_eff ? rx_bit : 1'b1;
  assign out_nx    = data_in ^ tap_mid ^ sr[SR_LEN-1];
  assign shift_bit = desc_eff ? rx_bit : out_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      out_q <= 1'b0;
    end else if (step) begin
      sr    <= {sr[SR_LEN-2:0], shift_bit};
      out_q <= out_nx;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(sr) && $stable(out_q))); // R5

  AST_DESC_SHIFTS_RX: assert property (@(posedge clk) disable iff (rst)
    (step && desc_eff) |=> (sr[0] == $past(rx_bit))); // R3

  AST_GEN_SHIFTS_OUT: assert property (@(posedge clk) disable iff (rst)
    (step && !desc_eff) |=> (sr[0] == out_q)); // R4

endmodule

// File: rtl/scr_lock_ctrl.sv
module scr_lock_ctrl
  import scr_sync_pkg::*;
#(
  parameter int TRAIN_SYMS  = 23,
  parameter int WINDOW_SYMS = 128,
  parameter int THR_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_en,
  input  logic             lock_en,
  input  logic             gen_bit,
  input  logic             rx_bit,
  input  logic [THR_W-1:0] thr,
  input  logic             irq_clr,
  output logic             ovr_desc,
  output logic             sync_flag
);

  localparam int CNT_MAX = max_int(TRAIN_SYMS, WINDOW_SYMS);
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int ACC_W   = $clog2(WINDOW_SYMS + 1);
  localparam int CMP_W   = max_int(ACC_W, THR_W);

  lock_phase_t      phase;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_nx;
  logic             match;
  logic             over;
  logic             hit;

  assign match    = (gen_bit == rx_bit);
  assign acc_nx   = acc + ACC_W'(match);
  assign over     = (CMP_W'(acc_nx) > CMP_W'(thr));
  assign hit      = lock_en && sym_en && (phase == PH_WINDOW) && over;
  assign ovr_desc = (phase == PH_IDLE) || (phase == PH_TRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      acc   <= '0;
    end else if (!lock_en) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase <= PH_TRAIN;
          cnt   <= '0;
          acc   <= '0;
        end
        PH_TRAIN: begin
          if (sym_en) begin
            if (cnt == CNT_W'(TRAIN_SYMS - 1)) begin
              phase <= PH_WINDOW;
              cnt   <= '0;
              acc   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_WINDOW: begin
          if (sym_en) begin
            if (over) begin
              phase <= PH_LOCKED;
            end else if (cnt == CNT_W'(WINDOW_SYMS - 1)) begin
              phase <= PH_TRAIN;
              cnt   <= '0;
              acc   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
              acc <= acc_nx;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      sync_flag <= 1'b0;
    else if (hit)                 sync_flag <= 1'b1;
    else if (irq_clr && !lock_en) sync_flag <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lock_en && sync_flag) |=> sync_flag); // R9

  AST_SET_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_flag) |-> $past(lock_en && phase == PH_WINDOW)); // R7

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    acc <= ACC_W'(WINDOW_SYMS)); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> (phase == PH_IDLE)); // R10

  AST_TRAIN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRAIN) |-> (cnt < CNT_W'(TRAIN_SYMS))); // R6

endmodule

// File: rtl/scr_autosync.sv
module scr_autosync
  import scr_sync_pkg::*;
#(
  parameter int SR_LEN      = 23,
  parameter int TAP_SEL1    = 18,
  parameter int TAP_SEL0    = 5,
  parameter int TRAIN_SYMS  = 23,
  parameter int WINDOW_SYMS = 128,
  parameter int THR_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_en,
  input  logic             det_bit,
  input  logic             poly_sel,
  input  logic             desc_mode,
  input  logic             lock_en,
  input  logic [THR_W-1:0] sync_thr,
  input  logic             irq_clr,
  output logic             scr_out,
  output logic             sync_irq
);

  logic ovr_desc;
  logic desc_eff;
  logic gen_bit;

  assign desc_eff = lock_en ? ovr_desc : desc_mode;

  scr_lfsr_core #(
    .SR_LEN  (SR_LEN),
    .TAP_SEL1(TAP_SEL1),
    .TAP_SEL0(TAP_SEL0)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (sym_en),
    .desc_eff(desc_eff),
    .poly_sel(poly_sel),
    .rx_bit  (det_bit),
    .out_nx  (gen_bit),
    .out_q   (scr_out)
  );

  scr_lock_ctrl #(
    .TRAIN_SYMS (TRAIN_SYMS),
    .WINDOW_SYMS(WINDOW_SYMS),
    .THR_W      (THR_W)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .sym_en   (sym_en),
    .lock_en  (lock_en),
    .gen_bit  (gen_bit),
    .rx_bit   (det_bit),
    .thr      (sync_thr),
    .irq_clr  (irq_clr),
    .ovr_desc (ovr_desc),
    .sync_flag(sync_irq)
  );

  AST_SYNC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_irq) |-> $past(lock_en)); // R9

endmodule

// File: tb/tb_scr_autosync.sv
module tb_scr_autosync;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_en = 1'b0;
  logic       det_bit = 1'b0;
  logic       poly_sel = 1'b1;
  logic       desc_mode = 1'b1;
  logic       lock_en = 1'b0;
  logic [7:0] sync_thr = 8'd10;
  logic       irq_clr = 1'b0;
  logic       scr_out;
  logic       sync_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_autosync dut (
    .clk(clk), .rst(rst), .sym_en(sym_en), .det_bit(det_bit),
    .poly_sel(poly_sel), .desc_mode(desc_mode), .lock_en(lock_en),
    .sync_thr(sync_thr), .irq_clr(irq_clr),
    .scr_out(scr_out), .sync_irq(sync_irq)
  );

  // behavioural reference model
  logic [22:0] m_sr = '0;
  logic        m_out = 1'b0;
  logic        m_flag = 1'b0;
  int          m_ph = 0;
  int          m_cnt = 0;
  int          m_acc = 0;

  always @(posedge clk) begin
    logic desc, tapb, o, hit;
    int a;
    if (rst) begin
      m_sr = '0; m_out = 0; m_flag = 0; m_ph = 0; m_cnt = 0; m_acc = 0;
    end else begin
      desc = lock_en ? (m_ph <= 1) : desc_mode;
      tapb = poly_sel ? m_sr[17] : m_sr[4];
      o    = (desc ? det_bit : 1'b1) ^ tapb ^ m_sr[22];
      hit  = 0;
      if (!lock_en) m_ph = 0;
      else if (m_ph == 0) begin m_ph = 1; m_cnt = 0; m_acc = 0; end
      else if (m_ph == 1 && sym_en) begin
        if (m_cnt == 22) begin m_ph = 2; m_cnt = 0; m_acc = 0; end
        else m_cnt++;
      end else if (m_ph == 2 && sym_en) begin
        a = m_acc + ((o == det_bit) ? 1 : 0);
        if (a > int'(sync_thr)) begin m_ph = 3; hit = 1; end
        else if (m_cnt == 127) begin m_ph = 1; m_cnt = 0; m_acc = 0; end
        else begin m_cnt++; m_acc = a; end
      end
      if (hit) m_flag = 1;
      else if (irq_clr && !lock_en) m_flag = 0;
      if (sym_en) begin
        m_out = o;
        m_sr  = {m_sr[21:0], desc ? det_bit : o};
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R2 R3 R4 R6 R8 R10 scr_out vs model", scr_out, m_out);
      chk("R7 R9 sync_irq vs model", sync_irq, m_flag);
    end
  end

  // far-end scrambled-ones source
  logic [22:0] fe_sr = 23'h1;
  function automatic logic fe_next(input logic psel);
    logic o;
    o = 1'b1 ^ (psel ? fe_sr[17] : fe_sr[4]) ^ fe_sr[22];
    fe_sr = {fe_sr[21:0], o};
    return o;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // feed far-end bits until sync_irq rises; returns edge count
  task automatic run_to_sync(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      det_bit = fe_next(poly_sel);
      @(negedge clk);
      n++;
      if (sync_irq) break;
    end
  endtask

  initial begin
    int n;
    logic rec [0:29];
    logic held;
    do_reset();
    chk("R5 reset scr_out", scr_out, 0);
    chk("R5 reset sync_irq", sync_irq, 0);

    // R1 impulse, taps 18/23
    sym_en = 1; desc_mode = 1; poly_sel = 1;
    for (int k = 0; k <= 30; k++) begin
      det_bit = (k == 0);
      @(negedge clk);
      chk("R1 R3 impulse response", scr_out, (k == 0 || k == 18 || k == 23));
    end

    // R2 impulse, taps 5/23
    do_reset();
    poly_sel = 0;
    for (int k = 0; k <= 30; k++) begin
      det_bit = (k == 0);
      @(negedge clk);
      chk("R2 R3 impulse response", scr_out, (k == 0 || k == 5 || k == 23));
    end

    // R4 generator ignores det_bit
    do_reset();
    desc_mode = 0; poly_sel = 1;
    for (int k = 0; k < 30; k++) begin
      det_bit = 0; @(negedge clk); rec[k] = scr_out;
    end
    do_reset();
    for (int k = 0; k < 30; k++) begin
      det_bit = $urandom_range(0, 1); @(negedge clk);
      chk("R4 det_bit ignored", scr_out, rec[k]);
    end

    // R5 hold when sym_en low
    held = scr_out;
    sym_en = 0;
    for (int k = 0; k < 6; k++) begin
      det_bit = k[0]; @(negedge clk);
      chk("R5 hold without enable", scr_out, held);
    end
    sym_en = 1;
    for (int k = 0; k < 8; k++) begin
      det_bit = $urandom_range(0, 1); @(negedge clk);
    end

    // R6 R7 lock and sync timing, threshold 10
    do_reset();
    fe_sr = 23'h1; poly_sel = 1; desc_mode = 0; sync_thr = 8'd10; lock_en = 1;
    run_to_sync(400, n);
    chk("R6 R7 sync edge count", n, 35);
    for (int k = 0; k < 10; k++) begin
      desc_mode = k[0];
      det_bit = fe_next(poly_sel);
      @(negedge clk);
      chk("R7 generator tracks far end after sync", scr_out, det_bit);
    end

    // R9 clear blocked under lock, allowed after
    irq_clr = 1;
    repeat (2) @(negedge clk);
    chk("R9 clear ignored while locked", sync_irq, 1);
    lock_en = 0;
    @(negedge clk);
    chk("R9 clear after lock off", sync_irq, 0);
    irq_clr = 0;

    // R8 threshold 128 never reached, then restart with threshold 10
    do_reset();
    fe_sr = 23'h5; poly_sel = 0; sync_thr = 8'd128; lock_en = 1;
    run_to_sync(152, n);
    chk("R8 threshold 128 unreachable", sync_irq, 0);
    sync_thr = 8'd10;
    run_to_sync(400, n);
    chk("R8 restart training with cleared count", n, 23 + 11);

    // R8 threshold 127 reached on last window symbol
    lock_en = 0;
    do_reset();
    fe_sr = 23'h3; poly_sel = 1; sync_thr = 8'd127; lock_en = 1;
    run_to_sync(400, n);
    chk("R8 threshold 127 on last symbol", n, 152);

    // R10 abort mid-window, then restart
    lock_en = 0; irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    do_reset();
    fe_sr = 23'h1; sync_thr = 8'd200; lock_en = 1; desc_mode = 0;
    run_to_sync(30, n);
    lock_en = 0;
    for (int k = 0; k < 12; k++) begin
      det_bit = $urandom_range(0, 1); @(negedge clk);
    end
    chk("R10 no flag after abort", sync_irq, 0);
    sync_thr = 8'd10; lock_en = 1;
    run_to_sync(400, n);
    chk("R10 restart from training", n, 35);

    // mix in gated symbols while locked
    lock_en = 0; irq_clr = 1; @(negedge clk); irq_clr = 0;
    lock_en = 1;
    for (int k = 0; k < 200; k++) begin
      sym_en = (k % 3 != 0);
      det_bit = sym_en ? fe_next(poly_sel) : 1'b0;
      @(negedge clk);
    end
    sym_en = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule